// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address, a set of read/write/execute permissions and a fault code. A one-cycle `start` pulse loads the address, the page table base, the access mode (kernel or user), the permissions the access needs and a physical-bypass flag.

Bypassed accesses, malformed addresses and kernel direct-map (superpage) addresses are resolved without any memory traffic. Every other address is resolved by reading up to three page table entries. Each entry is read through a memory port that allows one outstanding request at a time.

The result appears together with a one-cycle `done` pulse. It stays on the outputs until the next result replaces it. TLB storage, bus errors and the raising of the exception belong to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `mem_req`, `fault`, `perm` and `paddr` are all zero.
- R2: A start with `phys_bypass`=1 returns `paddr` equal to `vaddr`, `perm`=3'b111 and `fault`=0. It issues no memory read, and `done` is high in the cycle after the start edge. The permission bits are bit0 read, bit1 write and bit2 execute.
- R3: Without bypass, bits 63:43 of `vaddr` must all be equal. If they are not, the result is `fault`=1 (access violation) one cycle after start, with no memory read.
- R4: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 is a superpage. In kernel mode (`user_mode`=0) the result is `fault`=0 and `perm`=3'b111. Its `paddr` holds bits 39:0 of `vaddr` in place, bit 40 of `vaddr` moved to bit 43, and zeros elsewhere. In user mode the result is `fault`=1. Both results arrive one cycle after start, with no memory read.
- R5: Any other address is walked in up to three reads. Each read is one `mem_req` pulse at base + index*8. The indices are `vaddr`[42:33], then [32:23], then [22:13]. The first base is `pt_base`, and each following base is entry bits 63:32 shifted left by 13. A request goes out in the cycle after start, or after the previous response. `done` rises in the cycle after the final response.
- R6: In the first- and second-level entries, bit 0 is the valid bit and bit 8 is kernel-read-enable. If bit 0 is clear, the walk stops with `fault`=2. If bit 0 is set but bit 8 is clear, the walk stops with `fault`=1.
- R7: In the leaf entry, a clear bit 0 gives `fault`=2. Read is granted by bit 8 in kernel mode or bit 9 in user mode, and a read grant gives both read and execute. Write is granted by bit 12 in kernel mode or bit 13 in user mode. If `need_perm` is nonzero and has no bit in common with the grant, the result is `fault`=1.
- R8: Leaf bits 1, 2 and 3 then withdraw read, write and execute respectively. If `need_perm` is nonzero and no needed permission remains, `fault` is 5 when execute is needed, otherwise 4 when write is needed, otherwise 3.
- R9: A successful walk returns `fault`=0, `perm` equal to the remaining permissions, and `paddr` equal to leaf bits 63:32 shifted left by 13, ORed with `vaddr`[12:0]. Any nonzero fault returns `paddr`=0 and `perm`=0.
- R10: `done` is high for exactly one cycle per result. The outputs hold until the next result. A `start` that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| vaddr | input | 64 | Virtual address |
| pt_base | input | 64 | First-level page table base |
| user_mode | input | 1 | 0 = kernel, 1 = user |
| phys_bypass | input | 1 | Treat the address as physical |
| need_perm | input | 3 | Needed permissions: bit0 read, bit1 write, bit2 execute |
| mem_req | output | 1 | One-cycle entry read request |
| mem_addr | output | 64 | Byte address of the entry |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 64 | Entry data |
| done | output | 1 | Result pulse |
| paddr | output | 64 | Physical address |
| perm | output | 3 | Granted permissions |
| fault | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |

## Verification
Bypass, malformed and superpage results are due exactly one cycle after the start edge. A walk that reads k entries from a memory answering L cycles after each request is due 1 + k*(L+1) cycles after start.

The driver task records the start cycle and pushes the expected result, latency and read count into a queue. The monitor samples at the falling edge whenever `done` is high and compares all of them. Any `done` pulse that arrives with an empty queue fails.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int ADDR_W     = 64;
    localparam int PAGE_SHIFT = 13;
    localparam int VA_BITS    = 43;
    localparam int IDX_W      = 10;
    localparam int LEVELS     = 3;
    localparam int PTE_SHIFT  = 3;

    // entry bit positions (decoded by the walk logic)
    localparam int PTE_V     = 0;
    localparam int PTE_FOR   = 1;
    localparam int PTE_FOE   = 3;
    localparam int PTE_RD_K  = 8;
    localparam int PTE_WR_K  = 12;

    // superpage remap: low bits kept, one bit relocated
    localparam int SP_KEEP   = 40;
    localparam int SP_DST    = 43;

    localparam logic [2:0] PERM_ALL = 3'b111;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ACCESS   = 3'd1,
        FLT_INVALID  = 3'd2,
        FLT_ON_READ  = 3'd3,
        FLT_ON_WRITE = 3'd4,
        FLT_ON_EXEC  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        LVL_TOP  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_LEAF = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    typedef struct packed {
        fault_e              fault;
        logic [ADDR_W-1:0]   paddr;
        logic [2:0]          perm;
    } xlat_res_t;

    typedef struct packed {
        logic      finish;
        xlat_res_t res;
    } classify_t;

    typedef struct packed {
        logic              stop;
        xlat_res_t         res;
        logic [ADDR_W-1:0] next_base;
    } entry_eval_t;

    function automatic fault_e fo_fault(logic [2:0] need);
        if (need[2])      return FLT_ON_EXEC;
        else if (need[1]) return FLT_ON_WRITE;
        else              return FLT_ON_READ;
    endfunction

endpackage

// File: rtl/pgw_classify.sv
module pgw_classify
    import pgw_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int VBITS = VA_BITS
) (
    input  logic [AW-1:0] vaddr,
    input  logic          bypass,
    input  logic          user,
    output classify_t     cls
);
    localparam int EXT_W = AW - VBITS;

    logic canonical;
    logic superpage;

    assign canonical = (vaddr[AW-1:VBITS] == {EXT_W{vaddr[AW-1]}});
    assign superpage = vaddr[AW-1] && (vaddr[VBITS-1:VBITS-2] == 2'b10);

    always_comb begin
        cls = '0;
        if (bypass) begin
            cls.finish     = 1'b1;
            cls.res.paddr  = vaddr;
            cls.res.perm   = PERM_ALL;
        end else if (!canonical) begin
            cls.finish     = 1'b1;
            cls.res.fault  = FLT_ACCESS;
        end else if (superpage) begin
            cls.finish = 1'b1;
            if (user) begin
                cls.res.fault = FLT_ACCESS;
            end else begin
                cls.res.paddr[SP_KEEP-1:0] = vaddr[SP_KEEP-1:0];
                cls.res.paddr[SP_DST]      = vaddr[SP_KEEP];
                cls.res.perm               = PERM_ALL;
            end
        end
    end

endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
    import pgw_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int PSHIFT = PAGE_SHIFT
) (
    input  logic [63:0]        pte,
    input  level_e             lvl,
    input  logic               user,
    input  logic [2:0]         need,
    input  logic [PSHIFT-1:0]  page_off,
    output entry_eval_t        ev
);
    logic       rd_ok;
    logic       wr_ok;
    logic [2:0] grant;
    logic [2:0] kept;
    logic [AW-1:0] frame_addr;
    logic       unused_bits;

    assign rd_ok      = user ? pte[PTE_RD_K+1] : pte[PTE_RD_K];
    assign wr_ok      = user ? pte[PTE_WR_K+1] : pte[PTE_WR_K];
    assign grant      = {rd_ok, wr_ok, rd_ok};
    assign kept       = grant & ~pte[PTE_FOE:PTE_FOR];
    assign frame_addr = AW'({pte[63:32], {PSHIFT{1'b0}}});
    assign unused_bits = ^{pte[31:14], pte[11:10], pte[7:4]};

    always_comb begin
        ev           = '0;
        ev.next_base = frame_addr;
        if (!pte[PTE_V]) begin
            ev.stop      = 1'b1;
            ev.res.fault = FLT_INVALID;
        end else if (lvl != LVL_LEAF) begin
            if (!pte[PTE_RD_K]) begin
                ev.stop      = 1'b1;
                ev.res.fault = FLT_ACCESS;
            end
        end else begin
            ev.stop = 1'b1;
            if ((need != 3'b000) && ((grant & need) == 3'b000)) begin
                ev.res.fault = FLT_ACCESS;
            end else if ((need != 3'b000) && ((kept & need) == 3'b000)) begin
                ev.res.fault = fo_fault(need);
            end else begin
                ev.res.perm  = kept;
                ev.res.paddr = frame_addr | AW'(page_off);
            end
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pgw_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int PSHIFT = PAGE_SHIFT,
    parameter int VBITS  = VA_BITS,
    parameter int IW     = IDX_W,
    parameter int NLVL   = LEVELS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] pt_base,
    input  logic          user_mode,
    input  logic          phys_bypass,
    input  logic [2:0]    need_perm,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          done,
    output logic [AW-1:0] paddr,
    output logic [2:0]    perm,
    output logic [2:0]    fault
);
    localparam int VA_KEEP = PSHIFT + NLVL * IW;

    walk_st_e             state_q;
    level_e               lvl_q;
    logic [AW-1:0]        base_q;
    logic [VA_KEEP-1:0]   va_q;
    logic                 user_q;
    logic [2:0]           need_q;
    xlat_res_t            res_q;
    logic                 done_q;
    logic                 st_idle;

    classify_t            cls;
    entry_eval_t          ev;
    logic [IW-1:0]        lvl_idx [NLVL];
    logic [IW-1:0]        cur_idx;

    pgw_classify #(.AW(AW), .VBITS(VBITS)) u_classify (
        .vaddr  (vaddr),
        .bypass (phys_bypass),
        .user   (user_mode),
        .cls    (cls)
    );

    pgw_entry_check #(.AW(AW), .PSHIFT(PSHIFT)) u_entry (
        .pte      (mem_rdata),
        .lvl      (lvl_q),
        .user     (user_q),
        .need     (need_q),
        .page_off (va_q[PSHIFT-1:0]),
        .ev       (ev)
    );

    // one index field per level, top level from the highest bits
    for (genvar g = 0; g < NLVL; g++) begin : g_idx
        assign lvl_idx[g] = va_q[PSHIFT + (NLVL-1-g)*IW +: IW];
    end

    assign cur_idx  = lvl_idx[lvl_q];
    assign mem_addr = base_q + (AW'(cur_idx) << PTE_SHIFT);
    assign mem_req  = (state_q == ST_ISSUE);
    assign st_idle  = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= LVL_TOP;
            base_q  <= '0;
            va_q    <= '0;
            user_q  <= 1'b0;
            need_q  <= 3'b000;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        va_q   <= vaddr[VA_KEEP-1:0];
                        user_q <= user_mode;
                        need_q <= need_perm;
                        base_q <= pt_base;
                        lvl_q  <= LVL_TOP;
                        if (cls.finish) begin
                            res_q  <= cls.res;
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (ev.stop) begin
                            res_q   <= ev.res;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            base_q  <= ev.next_base;
                            lvl_q   <= level_e'(lvl_q + 2'd1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign paddr = res_q.paddr;
    assign perm  = res_q.perm;
    assign fault = res_q.fault;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        idle,
    input logic        phys_bypass,
    input logic [63:0] vaddr,
    input logic        mem_req,
    input logic        done,
    input logic [63:0] paddr,
    input logic [2:0]  perm,
    input logic [2:0]  fault
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start && phys_bypass) |=>
            (done && fault == 3'd0 && perm == 3'b111 && paddr == $past(vaddr)));

    // R3
    noncanon_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start && !phys_bypass && (vaddr[63:43] != {21{vaddr[63]}}))
            |=> (done && fault == 3'd1));

    // R9
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 3'd0) |-> (paddr == 64'd0 && perm == 3'b000));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(paddr) && $stable(perm) && $stable(fault)));

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .idle        (st_idle),
    .phys_bypass (phys_bypass),
    .vaddr       (vaddr),
    .mem_req     (mem_req),
    .done        (done),
    .paddr       (paddr),
    .perm        (perm),
    .fault       (fault)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    localparam int LAT = 2;
    localparam logic [31:0] F_V  = 32'h0001;
    localparam logic [31:0] F_FR = 32'h0002;
    localparam logic [31:0] F_FW = 32'h0004;
    localparam logic [31:0] F_FX = 32'h0008;
    localparam logic [31:0] F_KR = 32'h0100;
    localparam logic [31:0] F_UR = 32'h0200;
    localparam logic [31:0] F_KW = 32'h1000;
    localparam logic [31:0] F_UW = 32'h2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] vaddr = '0;
    logic [63:0] pt_base = '0;
    logic        user_mode = 1'b0;
    logic        phys_bypass = 1'b0;
    logic [2:0]  need_perm = 3'b000;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [63:0] paddr;
    logic [2:0]  perm;
    logic [2:0]  fault;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .pt_base(pt_base),
        .user_mode(user_mode), .phys_bypass(phys_bypass), .need_perm(need_perm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .perm(perm), .fault(fault)
    );

    typedef struct {
        logic [2:0]  fault;
        logic [63:0] paddr;
        logic [2:0]  perm;
        int          lat;
        int          reads;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [63:0] mem [logic [63:0]];
    int total = 0, bad = 0, cyc = 0, start_cyc = 0, rd_count = 0;
    int sent = 0, got = 0, pend = 0;
    logic [63:0] pend_a = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] rd(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(logic [63:0] va, logic [63:0] ptb, logic usr,
                                   logic byp, logic [2:0] nd, string tag);
        exp_t e;
        logic [63:0] base, pte;
        logic [9:0] idx;
        logic r, w;
        logic [2:0] g, k;
        e.fault = 0; e.paddr = 0; e.perm = 0; e.reads = 0; e.lat = 1; e.tag = tag;
        if (byp) begin
            e.paddr = va; e.perm = 3'b111; return e;
        end
        if (va[63:43] != {21{va[63]}}) begin
            e.fault = 3'd1; return e;
        end
        if (va[63] && va[42:41] == 2'b10) begin
            if (usr) e.fault = 3'd1;
            else begin
                e.paddr = {20'd0, va[40], 3'd0, va[39:0]};
                e.perm  = 3'b111;
            end
            return e;
        end
        base = ptb;
        for (int l = 0; l < 3; l++) begin
            idx = va[33-10*l +: 10];
            pte = rd(base + {51'd0, idx, 3'b000});
            e.reads++;
            if (!pte[0]) begin e.fault = 3'd2; break; end
            if (l < 2) begin
                if (!pte[8]) begin e.fault = 3'd1; break; end
                base = {19'd0, pte[63:32], 13'd0};
            end else begin
                r = usr ? pte[9] : pte[8];
                w = usr ? pte[13] : pte[12];
                g = {r, w, r};
                k = g & ~pte[3:1];
                if (nd != 0 && (g & nd) == 0) e.fault = 3'd1;
                else if (nd != 0 && (k & nd) == 0)
                    e.fault = nd[2] ? 3'd5 : (nd[1] ? 3'd4 : 3'd3);
                else begin
                    e.perm  = k;
                    e.paddr = {19'd0, pte[63:32], va[12:0]};
                end
            end
        end
        e.lat = 1 + e.reads * (LAT + 1);
        return e;
    endfunction

    // memory responder: answers LAT falling edges after a request is seen
    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(pend_a);
            end
        end
        if (mem_req) begin
            pend_a = mem_addr;
            pend   = LAT;
            rd_count++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (done) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected done actual=1 expected=0");
            end else begin
                e = q.pop_front();
                chk({e.tag, " fault"}, 64'(fault), 64'(e.fault));
                chk({e.tag, " paddr"}, paddr, e.paddr);
                chk({e.tag, " perm"}, 64'(perm), 64'(e.perm));
                chk({e.tag, " latency"}, 64'(cyc - start_cyc), 64'(e.lat));
                chk({e.tag, " reads"}, 64'(rd_count), 64'(e.reads));
                got++;
            end
        end
    end

    task automatic map3(logic [63:0] va, logic [63:0] ptb, logic [31:0] f2, logic [31:0] fl1,
                        logic [31:0] f3, logic [31:0] fl2, logic [63:0] leaf);
        logic [63:0] t2, t3;
        t2 = {19'd0, f2, 13'd0};
        t3 = {19'd0, f3, 13'd0};
        mem[ptb + {51'd0, va[42:33], 3'b000}] = {f2, fl1};
        mem[t2  + {51'd0, va[32:23], 3'b000}] = {f3, fl2};
        mem[t3  + {51'd0, va[22:13], 3'b000}] = leaf;
    endtask

    task automatic run(logic [63:0] va, logic [63:0] ptb, logic usr, logic byp,
                       logic [2:0] nd, string tag);
        q.push_back(model(va, ptb, usr, byp, nd, tag));
        sent++;
        @(negedge clk);
        vaddr = va; pt_base = ptb; user_mode = usr; phys_bypass = byp; need_perm = nd;
        start = 1'b1; rd_count = 0; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        while (got < sent) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    localparam logic [63:0] PTB  = 64'h0000_0000_0020_0000;
    localparam logic [63:0] VA_A = 64'h0000_0012_3456_7ABC;
    localparam logic [63:0] VA_B = 64'hFFFF_F8AB_CDEF_0123;
    localparam logic [31:0] FR2  = 32'h0000_0111;
    localparam logic [31:0] FR3  = 32'h0000_0222;
    localparam logic [31:0] ULK  = F_V | F_KR;

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 mem_req", 64'(mem_req), 64'd0);
        chk("R1 fault", 64'(fault), 64'd0);
        chk("R1 perm", 64'(perm), 64'd0);
        chk("R1 paddr", paddr, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        run(64'hDEAD_BEEF_0123_4567, PTB, 1'b1, 1'b1, 3'b001, "R2 bypass");
        run(64'h0000_1000_0000_0000, PTB, 1'b0, 1'b0, 3'b001, "R3 positive noncanonical");
        run(64'hFFF0_0000_0000_0000, PTB, 1'b0, 1'b0, 3'b010, "R3 negative noncanonical");
        run({21'h1FFFFF, 2'b10, 1'b1, 40'h12_3456_789A}, PTB, 1'b0, 1'b0, 3'b001, "R4 superpage bit40 set");
        run({21'h1FFFFF, 2'b10, 1'b0, 40'hAB_CDEF_0123}, PTB, 1'b0, 1'b0, 3'b100, "R4 superpage bit40 clear");
        run({21'h1FFFFF, 2'b10, 1'b1, 40'h00_0000_1000}, PTB, 1'b1, 1'b0, 3'b001, "R4 superpage user");

        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h0000_0ABC, F_V | F_KR | F_KW});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b001, "R5 R9 kernel read walk");
        map3(VA_B, PTB, FR2 + 1, ULK, FR3 + 1, ULK, {32'h0001_2345, F_V | F_KR | F_UW});
        run(VA_B, PTB, 1'b1, 1'b0, 3'b010, "R7 R9 user write walk");
        map3(VA_A, PTB, FR2, F_KR, FR3, ULK, {32'h1, F_V | F_KR});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b001, "R6 level1 invalid");
        map3(VA_A, PTB, FR2, ULK, FR3, F_V, {32'h1, F_V | F_KR});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b001, "R6 level2 no kernel read");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h1, F_KR | F_KW});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b001, "R7 leaf invalid");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h1, F_V | F_KR | F_KW});
        run(VA_A, PTB, 1'b1, 1'b0, 3'b001, "R7 user lacks read");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h2, F_V | F_KR | F_FX});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b100, "R8 fault on execute");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h3, F_V | F_KW | F_FW});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b010, "R8 fault on write");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h4, F_V | F_UR | F_FR});
        run(VA_A, PTB, 1'b1, 1'b0, 3'b001, "R8 fault on read");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h5, F_V | F_KR | F_FR});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b101, "R8 execute survives read fault bit");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h6, F_V | F_KR | F_KW | F_FX | F_FW});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b110, "R8 execute outranks write");
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h7, F_V});
        run(VA_A, PTB, 1'b0, 1'b0, 3'b000, "R7 R9 nothing needed");

        // R10: start during a walk is ignored; result then holds
        map3(VA_A, PTB, FR2, ULK, FR3, ULK, {32'h0000_0ABC, F_V | F_KR | F_KW});
        q.push_back(model(VA_A, PTB, 1'b0, 1'b0, 3'b010, "R10 busy walk"));
        sent++;
        @(negedge clk);
        vaddr = VA_A; pt_base = PTB; user_mode = 1'b0; phys_bypass = 1'b0; need_perm = 3'b010;
        start = 1'b1; rd_count = 0; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        vaddr = 64'h5; phys_bypass = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; phys_bypass = 1'b0;
        while (got < sent) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R10 no extra result", 64'(q.size()), 64'd0);
        chk("R10 paddr held", paddr, {19'd0, 32'h0000_0ABC, VA_A[12:0]});
        chk("R10 perm held", 64'(perm), 64'd7);
        chk("R10 done low", 64'(done), 64'd0);

        finish_up();
    end

endmodule